// File: doc/BRIEF.md
# Streaming 5/3 Lifting Wavelet Stage

This block computes a one-level forward 5/3 integer wavelet transform along a single line of samples, in one pass over the stream. Samples enter one per accepted cycle. The block separates them into even-position and odd-position phases, then applies two lifting steps. A predict step produces the highpass coefficient and an update step produces the lowpass coefficient. Each input pair yields one output beat that carries a lowpass value, a highpass value and a flag that marks the final pair of the line.

Only three registered values are kept between samples: the latest even sample, the latest odd sample and the previous highpass result. No line or frame memory is needed. Line edges use symmetric extension. The line length is a parameter and must be even. A start-of-line strobe restarts the block at any point. The same stage can feed a column pass or a further decomposition level placed after it.

Top module: `wl53_stream`

## Requirements
- R1: During reset and right after it, `out_valid` is 0 and `in_ready` is 1.
- R2: For pair n away from the right edge, `out_hi` = a[2n+1] − floor((a[2n] + a[2n+2]) / 2), using signed arithmetic with two guard bits.
- R3: `out_lo` = a[2n] + floor((h[n] + h[n−1] + 2) / 4), where h is the highpass sequence.
- R4: For the first pair of a line (n = 0), h[−1] is taken equal to h[0].
- R5: For the last pair of a line, a[LINE_LEN] is replaced by a[LINE_LEN−2], so h = a[LINE_LEN−1] − a[LINE_LEN−2]. That pair is the only one with `out_last` = 1.
- R6: When `out_ready` was 1 in the previous cycle, `out_valid` is 1 exactly when the previous cycle accepted an even sample at position 2 or higher, or the odd sample at position LINE_LEN−1.
- R7: While `out_valid` = 1 and `out_ready` = 0, the output beat is held unchanged and `in_ready` is 0.
- R8: An accepted sample with `in_sol` = 1 becomes position 0 of a new line. Any partly received line is dropped, and that sample produces no output.
- R9: While `out_ready` = 1, `in_ready` = 1, so one sample can be accepted every cycle.
- R10: After position LINE_LEN−1 is accepted, the next sample starts a new line at position 0 even when `in_sol` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sol | input | 1 | Sample is the first of a line |
| in_sample | input | W | Signed input sample |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_lo | output | W+2 | Signed lowpass coefficient |
| out_hi | output | W+2 | Signed highpass coefficient |
| out_last | output | 1 | Beat is the final pair of the line |

## Verification
The assertions assume that `in_sol` is meaningful only together with `in_valid`. They also assume that the downstream side may change `out_ready` in any cycle. The reference model assumes that a line which omits `in_sol` follows a line that was fully received. The stimulus therefore leaves out the start strobe only after a complete line, and it sends partial lines only when a strobed line follows them. Sample values cover the full signed input range, including alternating extremes. This stresses the guard bits without breaking the input contract.

// File: rtl/wl53_pkg.sv
package wl53_pkg;
  localparam int GUARD = 2;

  // role of the sample being accepted this cycle
  typedef enum logic [1:0] {
    K_EVEN_FIRST,  // position 0: store only
    K_EVEN_PAIR,   // even position >= 2: completes previous pair
    K_ODD_MID,     // odd position, not last: store only
    K_ODD_LAST     // position LINE_LEN-1: completes last pair with mirror
  } kind_e;
endpackage

// File: rtl/wl53_phase.sv
module wl53_phase #(
  parameter int LINE_LEN = 16,
  parameter int PW = $clog2(LINE_LEN + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic            sol_i,
  output wl53_pkg::kind_e kind_o,
  output logic            first_o
);
  import wl53_pkg::*;

  localparam logic [PW-1:0] LAST_POS = PW'(LINE_LEN - 1);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] pos;

  always_comb pos = sol_i ? '0 : cnt_q;

  always_comb begin
    if (pos == '0)          kind_o = K_EVEN_FIRST;
    else if (!pos[0])       kind_o = K_EVEN_PAIR;
    else if (pos == LAST_POS) kind_o = K_ODD_LAST;
    else                    kind_o = K_ODD_MID;
    first_o = ((kind_o == K_EVEN_PAIR) && (pos == PW'(2))) ||
              ((kind_o == K_ODD_LAST)  && (pos == PW'(1)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (take_i) cnt_q <= (pos == LAST_POS) ? '0 : pos + 1'b1;
  end
endmodule

// File: rtl/wl53_lift.sv
module wl53_lift #(
  parameter int W  = 10,
  parameter int CW = W + wl53_pkg::GUARD
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take_i,
  input  wl53_pkg::kind_e      kind_i,
  input  logic                 first_i,
  input  logic signed [W-1:0]  x_i,
  output logic                 emit_o,
  output logic signed [CW-1:0] lo_o,
  output logic signed [CW-1:0] hi_o
);
  import wl53_pkg::*;

  // predict: odd minus floor of the mean of its even neighbours
  function automatic logic signed [CW-1:0] lift_predict(
    input logic signed [CW-1:0] odd,
    input logic signed [CW-1:0] left,
    input logic signed [CW-1:0] right);
    logic signed [CW:0] sum;
    sum = {left[CW-1], left} + {right[CW-1], right};
    return odd - CW'(sum >>> 1);
  endfunction

  // update: even plus rounded quarter of the two adjacent highpass values
  function automatic logic signed [CW-1:0] lift_update(
    input logic signed [CW-1:0] even,
    input logic signed [CW-1:0] dn,
    input logic signed [CW-1:0] dm1);
    logic signed [CW+1:0] t;
    t = {{2{dn[CW-1]}}, dn} + {{2{dm1[CW-1]}}, dm1} + (CW+2)'(2);
    return even + CW'(t >>> 2);
  endfunction

  logic signed [CW-1:0] xe, s0_q, d0_q, dprev_q;
  logic signed [CW-1:0] right, odd, dm1;

  always_comb begin
    xe     = {{GUARD{x_i[W-1]}}, x_i};
    emit_o = (kind_i == K_EVEN_PAIR) || (kind_i == K_ODD_LAST);
    right  = (kind_i == K_ODD_LAST) ? s0_q : xe;   // mirror at right edge
    odd    = (kind_i == K_ODD_LAST) ? xe : d0_q;
    hi_o   = lift_predict(odd, s0_q, right);
    dm1    = first_i ? hi_o : dprev_q;             // mirror at left edge
    lo_o   = lift_update(s0_q, hi_o, dm1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0_q    <= '0;
      d0_q    <= '0;
      dprev_q <= '0;
    end else if (take_i) begin
      if ((kind_i == K_EVEN_FIRST) || (kind_i == K_EVEN_PAIR)) s0_q <= xe;
      else                                                    d0_q <= xe;
      if (emit_o) dprev_q <= hi_o;
    end
  end
endmodule

// File: rtl/wl53_oreg.sv
module wl53_oreg #(
  parameter int CW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic signed [CW-1:0] lo_i,
  input  logic signed [CW-1:0] hi_i,
  input  logic                 last_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output logic signed [CW-1:0] lo_o,
  output logic signed [CW-1:0] hi_o,
  output logic                 last_o,
  output logic                 free_o
);
  always_comb free_o = !valid_o || ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      lo_o    <= '0;
      hi_o    <= '0;
      last_o  <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      lo_o    <= lo_i;
      hi_o    <= hi_i;
      last_o  <= last_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/wl53_stream.sv
module wl53_stream #(
  parameter int W        = 10,
  parameter int LINE_LEN = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_sol,
  input  logic signed [W-1:0]    in_sample,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic signed [W+1:0]    out_lo,
  output logic signed [W+1:0]    out_hi,
  output logic                   out_last
);
  import wl53_pkg::*;

  localparam int CW = W + GUARD;

  // named internal events, visible to the bound checker
  logic                 take;
  logic                 emit;
  logic                 first;
  kind_e                kind;
  logic signed [CW-1:0] lo_c, hi_c;

  always_comb take = in_valid && in_ready;

  wl53_phase #(.LINE_LEN(LINE_LEN)) phase_i (
    .clk(clk), .rst_n(rst_n), .take_i(take), .sol_i(in_sol),
    .kind_o(kind), .first_o(first));

  wl53_lift #(.W(W), .CW(CW)) lift_i (
    .clk(clk), .rst_n(rst_n), .take_i(take), .kind_i(kind), .first_i(first),
    .x_i(in_sample), .emit_o(emit), .lo_o(lo_c), .hi_o(hi_c));

  wl53_oreg #(.CW(CW)) oreg_i (
    .clk(clk), .rst_n(rst_n), .load_i(take && emit), .lo_i(lo_c), .hi_i(hi_c),
    .last_i(kind == K_ODD_LAST), .ready_i(out_ready), .valid_o(out_valid),
    .lo_o(out_lo), .hi_o(out_hi), .last_o(out_last), .free_o(in_ready));
endmodule

// File: rtl/wl53_stream_chk.sv
module wl53_stream_chk #(
  parameter int CW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 in_sol,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [CW-1:0] out_lo,
  input logic signed [CW-1:0] out_hi,
  input logic                 out_last,
  input logic                 take_w,
  input logic                 emit_w,
  input wl53_pkg::kind_e      kind_w
);
  import wl53_pkg::*;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_lo) && $stable(out_hi) && $stable(out_last)); // R7
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R7
  AST_SOL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    take_w && in_sol |=> !out_valid); // R8
  AST_PAIR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    take_w && emit_w |=> out_valid); // R6
  AST_READY_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready); // R9
  AST_LAST_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    take_w && (kind_w == K_ODD_LAST) |=> out_valid && out_last); // R5
  AST_MID_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    take_w && (kind_w == K_EVEN_PAIR) |=> out_valid && !out_last); // R5
endmodule

bind wl53_stream wl53_stream_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sol(in_sol), .out_valid(out_valid), .out_ready(out_ready),
  .out_lo(out_lo), .out_hi(out_hi), .out_last(out_last),
  .take_w(take), .emit_w(emit), .kind_w(kind));

// File: tb/wl53_stream_tb_top.sv
module wl53_stream_tb_top;
  localparam int W  = 10;
  localparam int LN = 16;
  localparam int CW = W + 2;
  localparam int LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_ready, in_sol, out_valid, out_ready, out_last;
  logic signed [W-1:0]  in_sample;
  logic signed [CW-1:0] out_lo, out_hi;

  always #4 clk = ~clk;  // 125 MHz

  wl53_stream #(.W(W), .LINE_LEN(LN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sol(in_sol), .in_sample(in_sample), .out_valid(out_valid),
    .out_ready(out_ready), .out_lo(out_lo), .out_hi(out_hi), .out_last(out_last));

  int n_vec = 0;
  int n_bad = 0;
  int stim_x[$];
  bit stim_sol[$];
  int exp_lo[$];
  int exp_hi[$];
  bit exp_last[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // floor division by a positive divisor, written with integer ops only
  function automatic int fdiv(input int x, input int m);
    return (x >= 0) ? x / m : -((-x + m - 1) / m);
  endfunction

  // k samples of one line; full line when k == LN
  task automatic add_line(input int k, input bit with_sol, input int pat);
    int a[LN];
    int h[LN/2];
    int npair;
    for (int i = 0; i < LN; i++) begin
      case (pat)
        1:       a[i] = i * 37 - 300;
        2:       a[i] = (i % 2 == 0) ? 511 : -512;
        3:       a[i] = (i % 2 == 0) ? -512 : 511;
        default: a[i] = int'($urandom % 1024) - 512;
      endcase
    end
    for (int i = 0; i < k; i++) begin
      stim_x.push_back(a[i]);
      stim_sol.push_back(with_sol && (i == 0));
    end
    npair = (k == LN) ? LN/2 : (k - 1) / 2;
    for (int n = 0; n < npair; n++) begin
      int nb;
      nb = (2*n + 2 < LN) ? a[2*n+2] : a[LN-2];     // R5 right mirror
      h[n] = a[2*n+1] - fdiv(a[2*n] + nb, 2);       // R2
    end
    for (int n = 0; n < npair; n++) begin
      int hm;
      hm = (n == 0) ? h[0] : h[n-1];                // R4 left mirror
      exp_lo.push_back(a[2*n] + fdiv(h[n] + hm + 2, 4)); // R3
      exp_hi.push_back(h[n]);
      exp_last.push_back((k == LN) && (n == LN/2 - 1));
    end
  endtask

  initial begin
    int idx, cyc, bcnt;
    bit prev_rdy, prev_valid, prev_emit, prev_last;
    int prev_lo, prev_hi;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_sol = 1'b0; in_sample = '0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);

    add_line(LN, 1'b1, 1);   // ramp: R2 R3 R4 R5
    add_line(LN, 1'b1, 2);   // extremes: guard bits
    add_line(LN, 1'b1, 3);
    add_line(5, 1'b1, 0);    // partial line, then restart: R8
    add_line(LN, 1'b1, 0);
    add_line(3, 1'b1, 0);
    add_line(LN, 1'b1, 0);
    add_line(LN, 1'b0, 0);   // no start strobe: R10
    for (int l = 0; l < 40; l++) add_line(LN, 1'($urandom % 2), 0);

    idx = 0; cyc = 0; bcnt = 0;
    prev_rdy = 1'b0; prev_valid = 1'b0; prev_emit = 1'b0; prev_last = 1'b0;
    prev_lo = 0; prev_hi = 0;
    while ((idx < stim_x.size() || exp_lo.size() != 0) && cyc < LIMIT) begin
      if (cyc != 0) @(negedge clk);
      cyc++;
      if (prev_rdy)
        chk(out_valid == prev_emit, "R6 out_valid timing", int'(out_valid), int'(prev_emit));
      if (prev_valid && !prev_rdy)
        chk(out_valid && int'(out_lo) == prev_lo && int'(out_hi) == prev_hi && out_last == prev_last,
            "R7 beat held", int'(out_lo), prev_lo);
      out_ready = (cyc < 400) ? 1'b1 : (($urandom % 10) < 7);
      #1;
      if (out_ready) chk(in_ready == 1'b1, "R9 in_ready", int'(in_ready), 1);
      if (out_valid && !out_ready) chk(in_ready == 1'b0, "R7 in_ready", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        if (exp_lo.size() == 0) begin
          chk(1'b0, "R8 unexpected output", int'(out_lo), 0);
        end else begin
          int el, eh;
          bit ea;
          el = exp_lo.pop_front(); eh = exp_hi.pop_front(); ea = exp_last.pop_front();
          chk(int'(out_hi) == eh, "R2 highpass", int'(out_hi), eh);
          chk(int'(out_lo) == el, "R3 lowpass", int'(out_lo), el);
          chk(out_last == ea, "R5 last flag", int'(out_last), int'(ea));
        end
      end
      prev_emit = 1'b0;
      in_valid = (idx < stim_x.size()) && (($urandom % 8) != 0);
      if (in_valid) begin
        int bpos;
        in_sample = W'(stim_x[idx]);
        in_sol = stim_sol[idx];
        if (in_ready) begin
          bpos = stim_sol[idx] ? 0 : bcnt;   // R10 wrap handled by bcnt
          prev_emit = ((bpos % 2 == 0) && bpos >= 2) || (bpos == LN - 1);
          bcnt = (bpos == LN - 1) ? 0 : bpos + 1;
          idx++;
        end
      end else begin
        in_sol = 1'b0;
      end
      prev_rdy = out_ready; prev_valid = out_valid;
      prev_lo = int'(out_lo); prev_hi = int'(out_hi); prev_last = out_last;
    end
    if (cyc >= LIMIT) chk(1'b0, "watchdog expired", cyc, LIMIT);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(exp_lo.size() == 0, "R8 pairs outstanding", exp_lo.size(), 0);
    chk(out_valid == 1'b0, "R6 idle after drain", int'(out_valid), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule